// File: doc/BRIEF.md
# ADC Channel-Scan Sequencer with Limit Alarms

This block drives an external analog-to-digital converter through a sweep of input channels. The sweep runs from a programmable first channel up to a programmable last channel. A trigger pulse starts a sweep while the block is idle. For each channel the block issues a conversion request with the channel number and waits for the converter's result. It then writes the result into a staging register for that channel. The readable result registers are updated only once the sweep is complete, so a host never reads a mix of old and new samples.

Channels 0 to 3 are compared with a low and a high limit for each channel. A result outside its window raises that channel's alarm bit and pulls the active-low summary alarm output low. Each new sweep clears all alarm state.

A completed sweep is signalled in one of two ways:
- **Direct mode:** a status flag and an active-low pin are raised and held until the host reads the result registers.
- **Auto mode:** the flag never sets. When the internal trigger source is selected, each completed sweep produces one low pulse of fixed length on the pin, and the next sweep starts by itself.

Converter requests and responses are valid/ready streams:
- **Request:** the block holds `conv_req_valid_o` and `conv_ch_o` steady until `conv_req_ready_i` is high, so the converter can stall the block for as long as it needs.
- **Response:** the block raises `conv_rsp_ready_o` only while it waits for a result. The converter must hold `conv_rsp_valid_i` and the data until it sees ready.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the busy output is 0, the data-available flag is 0, the active-low data-available pin is 1, the alarm bits are 0, the active-low alarm output is 1, and every result register reads 0.
- R2: A trigger while idle starts a sweep. On the same clock edge the data-available flag and all alarm bits clear and the alarm output returns to 1.
- R3: A sweep requests channels in rising order, from the start address to the end address inclusive, one request per channel. If the end address is below the start address, only the start channel is converted.
- R4: Results go to staging registers. The result register for a channel keeps its previous value until the whole sweep is complete, and then all staged results are copied at once.
- R5: Channels 0 to 3 are range-checked against their own limits. A result strictly below the low limit or strictly above the high limit sets alarm bit n, where bit n belongs to channel n, and drives the alarm output to 0. Results equal to a limit are in range. Channels 4 and above never raise an alarm.
- R6: In direct mode (`auto_mode_i`=0), a completed sweep sets the flag to 1 and the pin to 0. Both hold until a read strobe `rd_i`, which returns the flag to 0 and the pin to 1.
- R7: In auto mode (`auto_mode_i`=1), the flag stays 0. With `int_trig_i`=1, each completed sweep drives the pin low for exactly PULSE_CYCLES cycles, and a new sweep starts without a trigger pulse.
- R8: A trigger that arrives while a sweep is running is ignored. The sweep's channel sequence is unchanged and no extra sweep follows.
- R9: While a request is not accepted, valid and channel stay steady. A response is taken only while `conv_rsp_ready_o` is 1.
- R10: After the results are copied, busy returns to 0 and the block stays idle until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Sweep trigger pulse |
| auto_mode_i | input | 1 | 1 = auto mode, 0 = direct mode |
| int_trig_i | input | 1 | Internal trigger source select (auto mode: free-running sweeps) |
| start_addr_i | input | AW | First channel of the sweep |
| end_addr_i | input | AW | Last channel of the sweep |
| lo_lim_i | input | NALM*DW | Low limits, channel n in bits n*DW upward |
| hi_lim_i | input | NALM*DW | High limits, channel n in bits n*DW upward |
| conv_req_valid_o | output | 1 | Conversion request valid |
| conv_req_ready_i | input | 1 | Converter accepts the request |
| conv_ch_o | output | AW | Channel to convert |
| conv_rsp_valid_i | input | 1 | Conversion result valid |
| conv_rsp_ready_o | output | 1 | Block is waiting for a result |
| conv_rsp_data_i | input | DW | Conversion result |
| rd_i | input | 1 | Host read strobe for the result registers |
| rd_ch_i | input | AW | Channel selected for reading |
| rd_data_o | output | DW | Committed result of the selected channel |
| dav_flag_o | output | 1 | Data-available flag |
| dav_n_o | output | 1 | Active-low data-available pin |
| alarm_bits_o | output | NALM | Alarm bits, one per checked channel |
| alarm_n_o | output | 1 | Active-low summary alarm |
| busy_o | output | 1 | Sweep in progress |

## Verification
Each channel takes a request cycle and then a wait cycle. An alarm bit changes on the clock edge that accepts an out-of-range result. The result registers, the flag and the pin change on the single commit edge after the last response, and busy falls on that same edge. A trigger's clearing effect is visible in the cycle after the trigger. The bench drives inputs and samples outputs on falling edges. It checks committed values at the first falling edge on which busy is low, and it checks trigger clearing at the falling edge right after the trigger edge. The auto-mode pulse is timed by counting falling edges while the pin is low.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_WAIT   = 2'd2,
    ST_COMMIT = 2'd3
  } scan_state_e;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic          req_ready,
  input  logic          rsp_valid,
  output scan_state_e   state,
  output logic [AW-1:0] addr,
  output logic          sweep_start,
  output logic          accept,
  output logic          commit
);
  logic last_ch;

  // Last channel: the end address is reached, or the range is inverted (start channel only)
  assign last_ch     = (addr >= end_addr) || (end_addr < start_addr);
  assign sweep_start = (state == ST_IDLE) && go;
  assign accept      = (state == ST_WAIT) && rsp_valid;
  assign commit      = (state == ST_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      addr  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          addr  <= start_addr;
          state <= ST_REQ;
        end
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (last_ch) state <= ST_COMMIT;
          else begin
            addr  <= addr + AW'(1);
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_regfile.sv
module scan_regfile #(
  parameter int AW = 4,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int NCH = 1 << AW;

  logic [DW-1:0] stage_q [NCH];
  logic [DW-1:0] data_q  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
        data_q[g]  <= '0;
      end else begin
        if (wr_en && (wr_addr == AW'(g))) stage_q[g] <= wr_data;
        if (commit) data_q[g] <= stage_q[g];
      end
    end
  end

  assign rd_data = data_q[rd_addr];
endmodule

// File: rtl/scan_alarm.sv
module scan_alarm #(
  parameter int AW   = 4,
  parameter int DW   = 12,
  parameter int NALM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              chk,
  input  logic [AW-1:0]     ch,
  input  logic [DW-1:0]     data,
  input  logic [NALM*DW-1:0] lo_lim,
  input  logic [NALM*DW-1:0] hi_lim,
  output logic [NALM-1:0]   bits,
  output logic              alarm_n
);
  logic [NALM-1:0] hit;

  for (genvar g = 0; g < NALM; g++) begin : g_lim
    assign hit[g] = chk && (ch == AW'(g)) &&
                    ((data < lo_lim[g*DW +: DW]) || (data > hi_lim[g*DW +: DW]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bits[g] <= 1'b0;
      else if (clr)    bits[g] <= 1'b0;
      else if (hit[g]) bits[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alarm_n <= 1'b1;
    else if (clr)    alarm_n <= 1'b1;
    else if (|hit)   alarm_n <= 1'b0;
  end
endmodule

// File: rtl/scan_dav.sv
module scan_dav #(
  parameter int PULSE_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic commit,
  input  logic rd,
  input  logic auto_mode,
  input  logic int_trig,
  output logic flag,
  output logic dav_n
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (commit && !auto_mode) flag <= 1'b1;
      else if (clr || rd)       flag <= 1'b0;
      if (commit && auto_mode && int_trig) pulse_q <= CW'(PULSE_CYCLES);
      else if (pulse_q != '0)              pulse_q <= pulse_q - CW'(1);
    end
  end

  assign dav_n = !(flag || (pulse_q != '0));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int AW           = 4,
  parameter int DW           = 12,
  parameter int NALM         = 4,
  parameter int PULSE_CYCLES = 200000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic               auto_mode_i,
  input  logic               int_trig_i,
  input  logic [AW-1:0]      start_addr_i,
  input  logic [AW-1:0]      end_addr_i,
  input  logic [NALM*DW-1:0] lo_lim_i,
  input  logic [NALM*DW-1:0] hi_lim_i,
  output logic               conv_req_valid_o,
  input  logic               conv_req_ready_i,
  output logic [AW-1:0]      conv_ch_o,
  input  logic               conv_rsp_valid_i,
  output logic               conv_rsp_ready_o,
  input  logic [DW-1:0]      conv_rsp_data_i,
  input  logic               rd_i,
  input  logic [AW-1:0]      rd_ch_i,
  output logic [DW-1:0]      rd_data_o,
  output logic               dav_flag_o,
  output logic               dav_n_o,
  output logic [NALM-1:0]    alarm_bits_o,
  output logic               alarm_n_o,
  output logic               busy_o
);
  scan_state_e   state;
  logic [AW-1:0] addr;
  logic          sweep_start, accept, commit, go;

  // Free-running sweeps in auto mode with the internal source selected
  assign go = trig_i || (auto_mode_i && int_trig_i);

  scan_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go),
    .start_addr(start_addr_i), .end_addr(end_addr_i),
    .req_ready(conv_req_ready_i), .rsp_valid(conv_rsp_valid_i),
    .state(state), .addr(addr),
    .sweep_start(sweep_start), .accept(accept), .commit(commit)
  );

  scan_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept), .wr_addr(addr), .wr_data(conv_rsp_data_i),
    .commit(commit), .rd_addr(rd_ch_i), .rd_data(rd_data_o)
  );

  scan_alarm #(.AW(AW), .DW(DW), .NALM(NALM)) u_alarm (
    .clk(clk), .rst_n(rst_n), .clr(sweep_start), .chk(accept),
    .ch(addr), .data(conv_rsp_data_i),
    .lo_lim(lo_lim_i), .hi_lim(hi_lim_i),
    .bits(alarm_bits_o), .alarm_n(alarm_n_o)
  );

  scan_dav #(.PULSE_CYCLES(PULSE_CYCLES)) u_dav (
    .clk(clk), .rst_n(rst_n), .clr(sweep_start), .commit(commit),
    .rd(rd_i), .auto_mode(auto_mode_i), .int_trig(int_trig_i),
    .flag(dav_flag_o), .dav_n(dav_n_o)
  );

  assign conv_req_valid_o = (state == ST_REQ);
  assign conv_rsp_ready_o = (state == ST_WAIT);
  assign conv_ch_o        = addr;
  assign busy_o           = (state != ST_IDLE);
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int AW   = 4,
  parameter int NALM = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trig_i,
  input logic            auto_mode_i,
  input logic            rd_i,
  input logic            conv_req_valid_o,
  input logic            conv_req_ready_i,
  input logic [AW-1:0]   conv_ch_o,
  input logic            conv_rsp_valid_i,
  input logic            conv_rsp_ready_o,
  input logic            dav_flag_o,
  input logic [NALM-1:0] alarm_bits_o,
  input logic            alarm_n_o,
  input logic            busy_o
);
  // R2
  sweep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (alarm_bits_o == '0) && alarm_n_o && !dav_flag_o);

  // R5
  alarm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|alarm_bits_o) |->
      $past(conv_rsp_valid_i && conv_rsp_ready_o && (conv_ch_o < AW'(NALM))));

  // R6
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_flag_o) |-> ($past(rd_i) || busy_o));

  // R7
  flag_direct_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_flag_o) |-> !$past(auto_mode_i));

  // R8
  busy_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && conv_req_valid_o) |=> busy_o);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid_o && !conv_req_ready_i) |=> conv_req_valid_o && $stable(conv_ch_o));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.AW(AW), .NALM(NALM)) u_chk (.*);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  localparam int AW = 4, DW = 12, NALM = 4, PC = 8;

  logic clk = 0, rst_n = 0;
  logic trig_i = 0, auto_mode_i = 0, int_trig_i = 0;
  logic [AW-1:0] start_addr_i = 0, end_addr_i = 0, conv_ch_o, rd_ch_i = 0;
  logic [NALM*DW-1:0] lo_lim_i, hi_lim_i;
  logic conv_req_valid_o, conv_req_ready_i = 1, conv_rsp_valid_i = 0, conv_rsp_ready_o;
  logic [DW-1:0] conv_rsp_data_i = 0, rd_data_o;
  logic rd_i = 0, dav_flag_o, dav_n_o, alarm_n_o, busy_o;
  logic [NALM-1:0] alarm_bits_o;

  int errors = 0, checks = 0;
  logic [DW-1:0] conv_val [16];
  int nreq = 0;
  logic [AW-1:0] req_ch [64];

  always #2.5 clk = ~clk;

  adc_scan_seq #(.AW(AW), .DW(DW), .NALM(NALM), .PULSE_CYCLES(PC)) u_dut (.*);

  // Converter model: one cycle of latency, result taken from conv_val
  always @(posedge clk) begin
    if (conv_rsp_ready_o && !conv_rsp_valid_i) begin
      conv_rsp_valid_i <= 1'b1;
      conv_rsp_data_i  <= conv_val[conv_ch_o];
    end else conv_rsp_valid_i <= 1'b0;
    if (conv_req_valid_o && conv_req_ready_i) begin
      if (nreq < 64) req_ch[nreq] <= conv_ch_o;
      nreq <= nreq + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic trig_pulse();
    @(negedge clk) trig_i = 1;
    @(negedge clk) trig_i = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic run_sweep(input int s, input int e);
    start_addr_i = AW'(s); end_addr_i = AW'(e);
    @(negedge clk); nreq = 0;
    trig_pulse();
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 flag", dav_flag_o, 0);
    chk("R1 dav_n", dav_n_o, 1);
    chk("R1 alarm bits", alarm_bits_o, 0);
    chk("R1 alarm_n", alarm_n_o, 1);
    rd_ch_i = 5; #0.1;
    chk("R1 data", rd_data_o, 0);
  endtask

  task automatic t_direct();
    for (int i = 0; i < 16; i++) conv_val[i] = DW'(200 + 17*i);
    run_sweep(2, 5);
    chk("R3 count", nreq, 4);
    for (int i = 0; i < 4; i++) chk("R3 order", req_ch[i], 2 + i);
    chk("R10 idle", busy_o, 0);
    for (int i = 2; i <= 5; i++) begin
      rd_ch_i = AW'(i); #0.1;
      chk("R4 commit", rd_data_o, 200 + 17*i);
    end
    rd_ch_i = 6; #0.1;
    chk("R4 unswept", rd_data_o, 0);
    chk("R6 flag set", dav_flag_o, 1);
    chk("R6 pin low", dav_n_o, 0);
    repeat (5) @(negedge clk);
    chk("R10 stays idle", busy_o, 0);
    chk("R6 flag held", dav_flag_o, 1);
    rd_i = 1; @(negedge clk) rd_i = 0;
    chk("R6 flag cleared by read", dav_flag_o, 0);
    chk("R6 pin high after read", dav_n_o, 1);
  endtask

  task automatic t_staging();
    for (int i = 0; i < 16; i++) conv_val[i] = DW'(3000 - 9*i);
    start_addr_i = 2; end_addr_i = 5;
    @(negedge clk); nreq = 0;
    trig_pulse();
    while (nreq < 2) @(negedge clk);
    rd_ch_i = 2; #0.1;
    chk("R4 old value mid-sweep", rd_data_o, 200 + 34);
    wait_idle();
    rd_ch_i = 2; #0.1;
    chk("R4 new value after sweep", rd_data_o, 3000 - 18);
  endtask

  task automatic t_alarm();
    for (int i = 0; i < 16; i++) conv_val[i] = 12'd1000;
    conv_val[0] = 100; conv_val[1] = 50; conv_val[2] = 3000;
    conv_val[3] = 3500; conv_val[4] = 10; conv_val[5] = 4000;
    run_sweep(0, 5);
    chk("R5 alarm bits", alarm_bits_o, 4'b1010);
    chk("R5 alarm_n low", alarm_n_o, 0);
    // Next trigger clears alarm state and the flag on its edge (R2)
    start_addr_i = 8; end_addr_i = 9;
    @(negedge clk) trig_i = 1;
    @(negedge clk) trig_i = 0;
    chk("R2 busy", busy_o, 1);
    chk("R2 alarm bits cleared", alarm_bits_o, 0);
    chk("R2 alarm_n high", alarm_n_o, 1);
    chk("R2 flag cleared", dav_flag_o, 0);
    wait_idle();
    chk("R5 unchecked channels", alarm_n_o, 1);
  endtask

  task automatic t_inverted();
    run_sweep(7, 3);
    chk("R3 inverted range count", nreq, 1);
    chk("R3 inverted range channel", req_ch[0], 7);
  endtask

  task automatic t_ignore_trig();
    start_addr_i = 1; end_addr_i = 4;
    @(negedge clk); nreq = 0;
    trig_pulse();
    repeat (3) @(negedge clk);
    trig_pulse();
    wait_idle();
    repeat (6) @(negedge clk);
    chk("R8 conversions", nreq, 4);
    chk("R8 no extra sweep", busy_o, 0);
  endtask

  task automatic t_stall();
    conv_req_ready_i = 0;
    start_addr_i = 6; end_addr_i = 6;
    trig_pulse();
    repeat (4) @(negedge clk);
    chk("R9 valid held", conv_req_valid_o, 1);
    chk("R9 channel held", conv_ch_o, 6);
    chk("R9 no rsp ready", conv_rsp_ready_o, 0);
    conv_req_ready_i = 1;
    wait_idle();
    rd_ch_i = 6; #0.1;
    chk("R9 result after stall", rd_data_o, conv_val[6]);
  endtask

  task automatic t_auto();
    int low = 0, n = 0, flag_seen = 0, sweeps = 0;
    logic pb;
    rd_i = 1; @(negedge clk) rd_i = 0;
    auto_mode_i = 1; int_trig_i = 1;
    start_addr_i = 0; end_addr_i = 3;
    pb = busy_o;
    while (dav_n_o && n < 500) begin
      @(negedge clk); n++;
      if (dav_flag_o) flag_seen = 1;
      if (busy_o && !pb) sweeps++;
      pb = busy_o;
    end
    while (!dav_n_o && low < 500) begin
      low++; @(negedge clk);
      if (dav_flag_o) flag_seen = 1;
      if (busy_o && !pb) sweeps++;
      pb = busy_o;
    end
    chk("R7 pulse width", low, PC);
    chk("R7 self restart", int'(sweeps >= 2), 1);
    chk("R7 flag stays clear", flag_seen, 0);
    int_trig_i = 0;
    @(negedge clk); wait_idle();
    repeat (20) @(negedge clk);
    chk("R10 idle after auto", busy_o, 0);
    // External trigger in auto mode: no pulse, no flag
    trig_pulse();
    flag_seen = 0; low = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!dav_n_o) low++;
      if (dav_flag_o) flag_seen = 1;
    end
    chk("R7 no pulse external", low, 0);
    chk("R7 flag external", flag_seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) conv_val[i] = 0;
    for (int i = 0; i < NALM; i++) begin
      lo_lim_i[i*DW +: DW] = 100;
      hi_lim_i[i*DW +: DW] = 3000;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_direct();
    t_staging();
    t_alarm();
    t_inverted();
    t_ignore_trig();
    t_stall();
    t_auto();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule